// File: doc/BRIEF.md
# Shared-Line Serial ADC Master

This block is the master side of a serial A/D converter link where command and result travel over one bidirectional data wire. When the host pulses `start`, the block opens a frame by pulling chip select low. It then shifts out a 4-bit command with `sdo_oe` asserted. After that it hands the wire to the converter and clocks in an 8-bit conversion result. Finally it closes the frame and presents the byte on `result` with a one-cycle `done` pulse.

The serial clock is built from the system clock. Each half-period lasts `HALF` system cycles. The command nibble is formed from a leading 1 followed by the three host configuration bits. Each command bit is placed on the wire while `sclk` is low, so it is stable across the rising edge where the converter latches it.

The block releases the wire inside the high phase that follows the fourth rising edge. From the fourth falling edge on, the converter drives the wire. The read phase runs `DATA_W+1` sample-then-pulse iterations, and the first sample is dropped. The board-level tristate pad is outside the block: it combines `sdo`, `sdo_oe` and the pad input `sdi`.

The controller is a Moore machine with six states:
- `ST_IDLE` goes to `ST_CMD_LO` on `start`.
- `ST_CMD_LO` goes to `ST_CMD_HI` after a half-period.
- `ST_CMD_HI` goes back to `ST_CMD_LO` while command bits remain, and to `ST_RD_LO` after the last one.
- `ST_RD_LO` samples the wire and goes to `ST_RD_HI`.
- `ST_RD_HI` goes back to `ST_RD_LO` while iterations remain, and to `ST_GUARD` after the last one, pulsing `done`.
- `ST_GUARD` goes to `ST_IDLE` after a half-period.

Every state other than `ST_IDLE` lasts exactly one half-period.

Top module: `shared_line_adc_master`

## Requirements
- R1: During and right after reset: `cs_n`=1, `sclk`=0, `sdo_oe`=0, `busy`=0, `done`=0.
- R2: A `start` sampled while idle makes `cs_n` fall and `busy` rise on the next system cycle.
- R3: The four command bits go out in this order: 1, `cfg[2]` (single-ended/differential select), `cfg[1]` (odd/sign select), `cfg[0]` (MSB-first select). Each bit is driven with `sdo_oe`=1 and is valid at its rising `sclk` edge.
- R4: Every `sclk` high and low phase inside a frame lasts `HALF` system cycles. `sclk` is low whenever `cs_n` is high.
- R5: `sdo_oe` is high only while `cs_n` is low. It falls while `sclk` is high after the 4th rising edge and is low before the 4th falling edge. Master and converter never drive the wire together.
- R6: The wire is sampled once per read iteration, at the end of each `sclk` low phase. There are `DATA_W+1` iterations, the first sample is discarded, and the rest form `result` MSB first (the first kept bit lands in bit 7).
- R7: `done` is a single-cycle pulse in the cycle `cs_n` returns high. `result` holds its value until the next `done`.
- R8: A frame has exactly 4 + `DATA_W` + 1 = 13 rising `sclk` edges.
- R9: `start` is ignored while `busy` is high, including during the guard interval. The frame in progress and its result are unaffected.
- R10: `cs_n` stays high at least `HALF` cycles between frames. `busy` stays high from the accepted start until that guard interval has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion frame (accepted only when idle) |
| cfg | input | 3 | Command bits: [2] single/differential, [1] odd/sign, [0] MSB-first |
| result | output | DATA_W | Last received conversion byte |
| busy | output | 1 | Frame or guard interval in progress |
| done | output | 1 | One-cycle pulse: `result` is new |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdo | output | 1 | Data driven onto the shared wire |
| sdo_oe | output | 1 | Output enable for the shared-wire pad |
| sdi | input | 1 | Level seen on the shared wire |

## Verification
All eight configuration nibbles are sent, each paired with a different result byte: 00, FF, A5, 5A, 80, 01, 3C and C3.
- The all-zero and all-one bytes expose a stuck or missing shift.
- The alternating bytes expose a swapped or off-by-one bit order.
- The single-bit bytes 80 and 01 show whether the dummy first sample was kept or dropped.

The bench converter model drives a 0 dummy bit on the 4th falling edge, so a design that keeps it loses B0. Back-to-back frames measure the guard interval. Start pulses placed mid-frame and in the guard interval show whether a request leaks past `busy`.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD_LO,
        ST_CMD_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_GUARD
    } sadc_state_e;

    localparam int CMD_BITS = 4;

endpackage

// File: rtl/sadc_half_timer.sv
module sadc_half_timer #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic first
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick  = run && (cnt == LAST);
    assign first = (cnt == '0);

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/sadc_cmd_shifter.sv
module sadc_cmd_shifter #(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NBITS-2:0] cfg,
    input  logic             shift,
    output logic             bit_out
);
    logic [NBITS-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= {1'b1, cfg};
        end else if (shift) begin
            sr <= {sr[NBITS-2:0], 1'b0};
        end
    end

    assign bit_out = sr[NBITS-1];

endmodule

// File: rtl/sadc_rx_capture.sv
module sadc_rx_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              sdi,
    input  logic              commit,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample) begin
            rx_sr <= {rx_sr[DATA_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (commit) begin
            result <= rx_sr;
        end
    end

    // R7: the byte only changes when a frame completes
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(result));

endmodule

// File: rtl/shared_line_adc_master.sv
module shared_line_adc_master #(
    parameter int HALF   = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cfg,
    output logic [DATA_W-1:0] result,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              sdi
);
    import sadc_pkg::*;

    localparam int RD_ITERS = DATA_W + 1;
    localparam int BW       = $clog2(RD_ITERS + 1);
    localparam logic [BW-1:0] CMD_LAST = BW'(CMD_BITS - 1);
    localparam logic [BW-1:0] RD_LAST  = BW'(RD_ITERS - 1);

    sadc_state_e state, state_nx;
    logic [BW-1:0] bit_idx, bit_idx_nx;
    logic tick, first, run;
    logic cmd_bit, sample, commit;

    initial assert (HALF >= 2) else $error("HALF must be at least 2");

    assign run    = (state != ST_IDLE);
    assign sample = (state == ST_RD_LO) && tick;
    assign commit = (state == ST_RD_HI) && tick && (bit_idx == RD_LAST);

    sadc_half_timer #(.HALF(HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .first (first)
    );

    sadc_cmd_shifter #(.NBITS(CMD_BITS)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    ((state == ST_IDLE) && start),
        .cfg     (cfg),
        .shift   ((state == ST_CMD_HI) && tick),
        .bit_out (cmd_bit)
    );

    sadc_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .sdi    (sdi),
        .commit (commit),
        .result (result)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            state   <= state_nx;
            bit_idx <= bit_idx_nx;
            done    <= commit;
        end
    end

    // next-state logic
    always_comb begin
        state_nx   = state;
        bit_idx_nx = bit_idx;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx   = ST_CMD_LO;
                    bit_idx_nx = '0;
                end
            end
            ST_CMD_LO: begin
                if (tick) state_nx = ST_CMD_HI;
            end
            ST_CMD_HI: begin
                if (tick) begin
                    if (bit_idx == CMD_LAST) begin
                        state_nx   = ST_RD_LO;
                        bit_idx_nx = '0;
                    end else begin
                        state_nx   = ST_CMD_LO;
                        bit_idx_nx = bit_idx + 1'b1;
                    end
                end
            end
            ST_RD_LO: begin
                if (tick) state_nx = ST_RD_HI;
            end
            ST_RD_HI: begin
                if (tick) begin
                    if (bit_idx == RD_LAST) begin
                        state_nx = ST_GUARD;
                    end else begin
                        state_nx   = ST_RD_LO;
                        bit_idx_nx = bit_idx + 1'b1;
                    end
                end
            end
            ST_GUARD: begin
                if (tick) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register only
    always_comb begin
        cs_n   = 1'b0;
        sclk   = 1'b0;
        sdo_oe = 1'b0;
        busy   = 1'b1;
        unique case (state)
            ST_IDLE: begin
                cs_n = 1'b1;
                busy = 1'b0;
            end
            ST_CMD_LO: begin
                sdo_oe = 1'b1;
            end
            ST_CMD_HI: begin
                sclk   = 1'b1;
                sdo_oe = (bit_idx != CMD_LAST) || first;
            end
            ST_RD_LO: begin
            end
            ST_RD_HI: begin
                sclk = 1'b1;
            end
            ST_GUARD: begin
                cs_n = 1'b1;
            end
            default: begin
                cs_n = 1'b1;
            end
        endcase
    end

    assign sdo = sdo_oe & cmd_bit;

    assert_oe_framed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !cs_n);

    assert_oe_release_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sdo_oe) && !cs_n) |-> sclk);

    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    assert_done_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_cs_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done) |=> cs_n);

endmodule

// File: tb/test_shared_line_adc_master.sv
module test_shared_line_adc_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cfg = '0;
    logic [DATA_W-1:0] result;
    logic busy, done, cs_n, sclk, sdo, sdo_oe, sdi;
    logic slv_en = 1'b0;
    logic slv_bit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sdi = sdo_oe ? sdo : (slv_en ? slv_bit : 1'b1);

    shared_line_adc_master #(.HALF(HALF), .DATA_W(DATA_W)) i_shared_line_adc_master (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .result(result),
        .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
        .sdo_oe(sdo_oe), .sdi(sdi)
    );

    typedef struct packed {
        logic [2:0] cfg;
        logic [7:0] val;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor, converter model and scoreboard
    logic sclk_q = 1'b0, cs_q = 1'b1, oe_q = 1'b0, done_q = 1'b0;
    int rise_n = 0, fall_n = 0, run_n = 0, guard_n = 0;
    int opened = 0, closed = 0;
    bit cmd_bad = 0, per_bad = 0, oe_bad = 0, clash_bad = 0, idle_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && sclk) idle_bad = 1;
            if (sdo_oe && slv_en) clash_bad = 1;
            if (cs_q && !cs_n) begin
                if (opened > 0) check(guard_n >= HALF, "R10", "guard cycles", guard_n, HALF);
                opened++;
                rise_n = 0; fall_n = 0; run_n = 1;
                cmd_bad = 0; per_bad = 0; oe_bad = 0;
                if (exp_q.size() > 0) cur = exp_q[0];
            end else if (sclk != sclk_q) begin
                if (run_n != HALF) per_bad = 1;
                run_n = 1;
                if (sclk) begin
                    rise_n++;
                    if (rise_n <= 4) begin
                        logic [3:0] ew;
                        ew = {1'b1, cur.cfg};
                        if (!sdo_oe || sdo !== ew[4-rise_n]) cmd_bad = 1;
                    end
                end else begin
                    fall_n++;
                    if (fall_n == 4 && (oe_q || sdo_oe)) oe_bad = 1;
                    if (fall_n >= 4 && fall_n <= 12) begin
                        slv_en = 1'b1;
                        slv_bit = (fall_n == 4) ? 1'b0 : cur.val[12-fall_n];
                    end else begin
                        slv_en = 1'b0;
                    end
                end
            end else begin
                run_n++;
            end
            if (cs_n) guard_n++; else guard_n = 0;

            if (done_q) check(!done, "R7", "done width", done, 0);
            if (done) begin
                item_t it;
                closed++;
                if (exp_q.size() > 0) it = exp_q.pop_front(); else it = '0;
                check(result == it.val, "R6", "result byte", result, it.val);
                check(!cmd_bad, "R3", "command bits", cmd_bad, 0);
                check(!oe_bad && !clash_bad, "R5", "line release", {oe_bad, clash_bad}, 0);
                check(!per_bad, "R4", "sclk half period", per_bad, 0);
                check(rise_n == 13, "R8", "rising edges", rise_n, 13);
                check(cs_n && busy, "R7", "cs_n/busy at done", {cs_n, busy}, 2'b11);
            end
            sclk_q = sclk; cs_q = cs_n; oe_q = sdo_oe; done_q = done;
        end
    end

    task automatic frame(input logic [2:0] c, input logic [7:0] v);
        exp_q.push_back('{cfg: c, val: v});
        @(negedge clk);
        start = 1'b1; cfg = c;
        @(negedge clk);
        start = 1'b0;
        check(!cs_n && busy, "R2", "frame open", {cs_n, busy}, 2'b01);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog all: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [7:0] vals [8];
        logic [7:0] held;
        vals = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01, 8'h3C, 8'hC3};

        repeat (3) @(negedge clk);
        check(cs_n && !sclk && !sdo_oe && !busy && !done, "R1", "reset outputs",
              {cs_n, sclk, sdo_oe, busy, done}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !sclk && !sdo_oe && !busy && !done, "R1", "idle outputs",
              {cs_n, sclk, sdo_oe, busy, done}, 5'b10000);

        // all configurations, back to back
        for (int i = 0; i < 8; i++) begin
            frame(3'(i), vals[i]);
            wait_idle();
        end

        // R7: result held while the next frame runs
        held = result;
        frame(3'b010, 8'h96);
        repeat (30) @(negedge clk);
        check(result == held, "R7", "result held", result, held);
        wait_idle();

        // R9: start mid-frame and in the guard interval
        frame(3'b101, 8'h4E);
        repeat (40) @(negedge clk);
        start = 1'b1; cfg = 3'b010;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        start = 1'b1; cfg = 3'b111;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (3 * HALF) @(negedge clk);
        check(opened == closed, "R9", "frames opened vs closed", opened, closed);
        check(cs_n && !busy, "R9", "no extra frame", {cs_n, busy}, 2'b10);

        check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
        check(!idle_bad, "R4", "sclk low while cs_n high", idle_bad, 0);
        check(!clash_bad, "R5", "no line contention", clash_bad, 0);
        finish_sim();
    end

endmodule